// File: doc/BRIEF.md
# Secured Counting Memory Card Controller

This block is the control logic of a 104-bit memory card whose cells are addressed one bit at a time. The address space holds three regions. Addresses 0 to 15 hold fixed chip data. Addresses 16 to 23 hold an 8-bit user field whose bit 16 is a lock flag. Addresses 24 to 103 form a counter built from ten 8-bit stages. The host reaches the memory through a synchronous serial link. This link has a card reset line, a card clock line and a single open-drain data line. The host steps an address pointer, reads one bit at a time, and issues program or stage-erase commands.

A freshly delivered card is locked. In that state, stage 5 (addresses 64 to 71) acts as an attempt counter, and stages 6 to 8 (addresses 72 to 95) hold a hidden 24-bit transport code. To unlock the card, the host first programs an unused attempt bit. It then clocks the code in on the data line while the pointer passes through the code region. A match opens the card and clears the attempt bits. After personalisation, the host sets the lock flag, which freezes the user field. From then on the whole counter region serves as counting stages. The top stage (addresses 24 to 31) can only ever gain ones. This lets the lower stages be erased as a carry moves down.

The memory cells are modelled as a register array loaded at power-on reset. The serial inputs are sampled on the system clock `clk`.

Top module: `sec_count_card`

## Requirements
- R1: A rising edge of `card_rst` while `card_clk` is high sets the bit pointer to 0. A rising edge of `card_clk` while `card_rst` is low advances the pointer by one, and the pointer wraps from 103 to 0.
- R2: While `card_clk` and `card_rst` are both low, the addressed bit is presented on the line: a 0 asserts `dio_oe` (line pulled low) and a 1 leaves the line released. The line is always released while either `card_clk` or `card_rst` is high.
- R3: Addresses 0 to 15 never change. Every program or erase command aimed at them is rejected.
- R4: The user field (addresses 16 to 23) accepts program commands only while the card is unlocked and the lock flag (bit 16) is 0.
- R5: The counter is ten 8-bit stages at addresses 24 to 103, with stage k at addresses 24+8k to 31+8k. An accepted erase clears all 8 bits of the stage that holds the addressed bit. Stage 0 (addresses 24 to 31) rejects erase in every state.
- R6: While the card is locked and the lock flag is 0, addresses 72 to 95 read as 1 (line released). All other addresses read their stored value. The only command accepted in this state is a program of an attempt bit (addresses 64 to 71) that is still 0.
- R7: An accepted attempt-bit program arms a code comparison. On each pointer step taken from addresses 72 to 95, the line level is compared with the stored code bit. The step taken from 95 ends the attempt. If all 24 bits matched, the card unlocks and bits 64 to 71 are cleared. Otherwise the card stays locked. A pointer reset cancels an armed attempt.
- R8: Once all eight attempt bits are 1, every further attempt-bit program is rejected, so no comparison can be armed and the card stays locked.
- R9: Once the card is unlocked, every address reads its stored value. Counter and user addresses accept programs, and stages 1 to 9 accept erase.
- R10: With the lock flag set, the user field rejects every program. Counter addresses, including 64 to 95, accept program, and stages 1 to 9 accept erase.
- R11: A rising edge of `card_rst` while `card_clk` is low issues a command. A high line means program (set the addressed bit to 1) and a low line means stage erase. The `cmd_rej` output then shows 1 if the command was rejected and 0 if it was accepted. A rejected command leaves every bit unchanged.
- R12: After `rst_n`, addresses 0 to 15 hold the chip-data image, 72 to 95 hold the transport code, and all other bits are 0. The card is locked, the pointer is 0, and `cmd_rej` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock on which all card lines are sampled |
| rst_n | input | 1 | Active-low power-on reset |
| card_rst | input | 1 | Card reset/command strobe from the host |
| card_clk | input | 1 | Card clock from the host |
| dio_in | input | 1 | Level of the shared open-drain data line |
| dio_oe | output | 1 | When high, pulls the data line low |
| cmd_rej | output | 1 | Outcome of the most recent command, 1 when rejected |

## Verification
The assertions assume the host never raises `card_clk` and `card_rst` in the same system cycle. They also assume each card line holds for at least one system clock, so that every edge on those lines is seen as one event. The bench moves one card line per task step, and each step spans at least one full `clk` period. During a command it drives the data line only while `card_rst` is high, when the card is released. It drives code bits only while the card clock rises over the hidden region, where the card never drives.

// File: rtl/sec_count_card.sv
module sec_count_card #(
  parameter int ROM_BITS    = 16,
  parameter int USER_BITS   = 8,
  parameter int STAGE_BITS  = 8,
  parameter int N_STAGES    = 10,
  parameter int ERR_STAGE   = 5,
  parameter int CODE_STAGE  = 6,
  parameter int CODE_STAGES = 3,
  parameter logic [ROM_BITS-1:0]                ROM_IMAGE = 16'hA5C3,
  parameter logic [CODE_STAGES*STAGE_BITS-1:0]  TCODE     = 24'h5A3C96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_rst,
  input  logic card_clk,
  input  logic dio_in,
  output logic dio_oe,
  output logic cmd_rej
);
  localparam int CNT_BASE = ROM_BITS + USER_BITS;
  localparam int TOTAL    = CNT_BASE + N_STAGES * STAGE_BITS;
  localparam int AW       = $clog2(TOTAL);
  localparam int LOCK_ADR = ROM_BITS;
  localparam int TOP_HI   = CNT_BASE + STAGE_BITS - 1;
  localparam int ERR_LO   = CNT_BASE + ERR_STAGE * STAGE_BITS;
  localparam int ERR_HI   = ERR_LO + STAGE_BITS - 1;
  localparam int CODE_LO  = CNT_BASE + CODE_STAGE * STAGE_BITS;
  localparam int CODE_HI  = CODE_LO + CODE_STAGES * STAGE_BITS - 1;
  localparam logic [TOTAL-1:0] INIT = (TOTAL'(TCODE) << CODE_LO) | TOTAL'(ROM_IMAGE);

  logic [TOTAL-1:0] mem, emask, errm;
  logic [AW-1:0]    addr;
  logic [31:0]      a, stg;
  logic ck_q, rs_q, unl, armed, mism;

  assign a = 32'(addr);
  assign stg = (a - 32'(CNT_BASE)) / 32'(STAGE_BITS);

  wire lockf     = mem[LOCK_ADR];
  wire delivered = !lockf && !unl;
  wire clk_rise  = card_clk && !ck_q;
  wire rst_rise  = card_rst && !rs_q;
  wire do_cmd    = rst_rise && !card_clk;
  wire do_zero   = rst_rise && card_clk;
  wire do_step   = clk_rise && !card_rst;

  wire in_user = a >= 32'(ROM_BITS) && a < 32'(CNT_BASE);
  wire in_cnt  = a >= 32'(CNT_BASE);
  wire in_top  = in_cnt && a <= 32'(TOP_HI);
  wire in_err  = a >= 32'(ERR_LO) && a <= 32'(ERR_HI);
  wire in_code = a >= 32'(CODE_LO) && a <= 32'(CODE_HI);
  wire cur     = mem[addr];
  wire hidden  = delivered && in_code;

  wire prog_ok  = in_user ? (unl && !lockf) :
                  in_cnt  ? (!delivered || (in_err && !cur)) : 1'b0;
  wire erase_ok = in_cnt && !in_top && !delivered;
  wire cmd_ok   = dio_in ? prog_ok : erase_ok;

  always_comb begin
    emask = '0;
    errm  = '0;
    for (int i = CNT_BASE; i < TOTAL; i++) begin
      if (32'((i - CNT_BASE) / STAGE_BITS) == stg) emask[i] = 1'b1;
      if (i >= ERR_LO && i <= ERR_HI) errm[i] = 1'b1;
    end
  end

  assign dio_oe = !card_clk && !card_rst && !hidden && !cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem     <= INIT;
      addr    <= '0;
      ck_q    <= 1'b0;
      rs_q    <= 1'b0;
      unl     <= 1'b0;
      armed   <= 1'b0;
      mism    <= 1'b0;
      cmd_rej <= 1'b0;
    end else begin
      ck_q <= card_clk;
      rs_q <= card_rst;
      if (do_zero) begin
        addr  <= '0;
        armed <= 1'b0;
      end else if (do_step) begin
        addr <= (a == 32'(TOTAL - 1)) ? '0 : addr + 1'b1;
        if (armed && in_code) begin
          if (dio_in != cur) mism <= 1'b1;
          if (a == 32'(CODE_HI)) begin
            armed <= 1'b0;
            if (!mism && dio_in == cur) begin
              unl <= 1'b1;
              mem <= mem & ~errm;
            end
          end
        end
      end
      if (do_cmd) begin
        cmd_rej <= !cmd_ok;
        if (cmd_ok) begin
          if (dio_in) begin
            mem[addr] <= 1'b1;
            if (delivered && in_err) begin
              armed <= 1'b1;
              mism  <= 1'b0;
            end
          end else begin
            mem <= mem & ~emask;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sec_count_card_chk.sv
module sec_count_card_chk #(
  parameter int RW = 16,
  parameter int UW = 8,
  parameter int SW = 8,
  parameter int LW = 40,
  parameter int HW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          card_clk,
  input logic          card_rst,
  input logic          dio_oe,
  input logic          cmd_rej,
  input logic          do_cmd,
  input logic          unl,
  input logic          armed,
  input logic          lockf,
  input logic [RW-1:0] rom_q,
  input logic [UW-1:0] user_q,
  input logic [SW-1:0] top_q,
  input logic [LW-1:0] clo_q,
  input logic [HW-1:0] chi_q
);
  assert_rom_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rom_q));

  assert_released_when_strobed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (card_clk || card_rst) |-> !dio_oe);

  assert_top_never_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~top_q & $past(top_q)) == '0));

  assert_user_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lockf) |-> $stable(user_q));

  assert_locked_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!lockf && !unl) |-> ($stable(user_q) && $stable(clo_q) && $stable(chi_q)));

  assert_unlock_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl) |-> $past(armed));

  assert_status_on_command_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_rej) |-> $past(do_cmd));
endmodule

bind sec_count_card sec_count_card_chk #(
  .RW(ROM_BITS), .UW(USER_BITS), .SW(STAGE_BITS),
  .LW(ERR_LO - CNT_BASE), .HW(TOTAL - 1 - ERR_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .card_rst(card_rst),
  .dio_oe(dio_oe), .cmd_rej(cmd_rej), .do_cmd(do_cmd), .unl(unl),
  .armed(armed), .lockf(lockf),
  .rom_q(mem[ROM_BITS-1:0]),
  .user_q(mem[CNT_BASE-1:ROM_BITS]),
  .top_q(mem[TOP_HI:CNT_BASE]),
  .clo_q(mem[ERR_LO-1:CNT_BASE]),
  .chi_q(mem[TOTAL-1:ERR_HI+1])
);

// File: tb/sim_sec_count_card.sv
module sim_sec_count_card;
  localparam logic [15:0] ROM = 16'hA5C3;
  localparam logic [23:0] TC  = 24'h5A3C96;

  logic clk = 1'b0, rst_n = 1'b0, card_rst = 1'b0, card_clk = 1'b0, hdrv = 1'b1;
  logic dio_oe, cmd_rej;
  wire  line = hdrv & ~dio_oe;

  always #2 clk = ~clk;

  sec_count_card #(.ROM_IMAGE(ROM), .TCODE(TC)) u0 (
    .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .card_clk(card_clk),
    .dio_in(line), .dio_oe(dio_oe), .cmd_rej(cmd_rej));

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [103:0] m;
  bit unl, armed, mism;
  int addr;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (addr %0d)", req, act, exp, addr);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic bit dlv();
    return !m[16] && !unl;
  endfunction

  function automatic void minit();
    m = '0;
    m[15:0] = ROM;
    m[95:72] = TC;
    unl = 0; armed = 0; mism = 0; addr = 0;
  endfunction

  function automatic void mstep(bit v);
    if (armed && addr >= 72 && addr <= 95) begin
      if (v != m[addr]) mism = 1;
      if (addr == 95) begin
        armed = 0;
        if (!mism) begin unl = 1; m[71:64] = '0; end
      end
    end
    addr = (addr == 103) ? 0 : addr + 1;
  endfunction

  function automatic bit mok(bit prog, int a);
    if (prog) begin
      if (a < 16) return 0;
      if (a < 24) return unl && !m[16];
      if (!dlv()) return 1;
      return (a >= 64 && a <= 71) && !m[a];
    end
    return a >= 32 && !dlv();
  endfunction

  task automatic step(bit v);
    hdrv = v; card_clk = 1; tick();
    card_clk = 0; hdrv = 1; tick();
    mstep(v);
  endtask

  task automatic areset();
    card_clk = 1; tick();
    mstep(1'b1);
    card_rst = 1; tick();
    card_rst = 0; tick();
    card_clk = 0; tick();
    addr = 0; armed = 0;
  endtask

  task automatic goto_adr(int a);
    areset();
    repeat (a) step(1'b1);
  endtask

  task automatic read_exp(string req);
    tick();
    check(req, int'(line), (dlv() && addr >= 72 && addr <= 95) ? 1 : int'(m[addr]));
  endtask

  task automatic cmd(bit prog, string req);
    bit ok;
    int base;
    ok = mok(prog, addr);
    hdrv = prog; card_rst = 1; tick();
    card_rst = 0; hdrv = 1; tick();
    check(req, int'(cmd_rej), int'(!ok));
    if (ok) begin
      if (prog) begin
        if (dlv() && addr >= 64 && addr <= 71) begin armed = 1; mism = 0; end
        m[addr] = 1;
      end else begin
        base = 24 + ((addr - 24) / 8) * 8;
        for (int i = 0; i < 8; i++) m[base + i] = 0;
      end
    end
  endtask

  task automatic dump(string req);
    areset();
    for (int i = 0; i < 104; i++) begin
      read_exp(req);
      step(1'b1);
    end
  endtask

  task automatic run_code(int bad);
    while (addr != 96) begin
      if (addr >= 72 && addr <= 95) step(m[addr] ^ (addr == bad));
      else step(1'b1);
    end
  endtask

  task automatic rop(string req, bit skip_lock);
    int a;
    a = $urandom_range(0, 103);
    if (skip_lock && a == 16) a = 17;
    goto_adr(a);
    cmd(1'($urandom_range(0, 1)), req);
  endtask

  task automatic por();
    rst_n = 0; repeat (4) tick();
    rst_n = 1; tick();
    minit();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4406));
    minit();
    por();
    check("R12", int'(cmd_rej), 0);
    dump("R12");

    goto_adr(103); read_exp("R1");
    step(1'b1); read_exp("R1"); check("R1", addr, 0);
    step(1'b1); step(1'b1); read_exp("R1");
    goto_adr(5); areset(); read_exp("R1");

    goto_adr(2); read_exp("R2"); check("R2", int'(line), 0);
    card_clk = 1; tick(); check("R2", int'(line), 1);
    card_clk = 0; tick(); mstep(1'b1);

    goto_adr(3); cmd(1'b1, "R3"); cmd(1'b0, "R3");
    goto_adr(20); cmd(1'b1, "R6");
    goto_adr(40); cmd(1'b1, "R6"); cmd(1'b0, "R6");
    goto_adr(80); cmd(1'b1, "R6");
    goto_adr(70); cmd(1'b0, "R6");

    goto_adr(64); cmd(1'b1, "R7"); run_code(75);
    goto_adr(20); cmd(1'b1, "R7"); check("R7", int'(unl), 0);
    goto_adr(65); cmd(1'b1, "R7"); goto_adr(0); run_code(-1);
    goto_adr(20); cmd(1'b1, "R7");
    goto_adr(66); cmd(1'b1, "R7"); run_code(-1);
    check("R7", int'(unl), 1);
    dump("R7");

    goto_adr(21); cmd(1'b1, "R4"); cmd(1'b1, "R9");
    goto_adr(3); cmd(1'b0, "R3");
    goto_adr(30); cmd(1'b0, "R5"); cmd(1'b1, "R5");
    goto_adr(45); cmd(1'b1, "R5"); goto_adr(44); cmd(1'b0, "R5");
    goto_adr(100); cmd(1'b1, "R9");
    for (int k = 0; k < 60; k++) rop("R9", 1'b1);
    dump("R9");

    goto_adr(16); cmd(1'b1, "R10");
    goto_adr(18); cmd(1'b1, "R10"); cmd(1'b1, "R4");
    goto_adr(80); cmd(1'b1, "R10"); cmd(1'b0, "R10");
    goto_adr(26); cmd(1'b0, "R5");
    for (int k = 0; k < 50; k++) rop("R10", 1'b0);
    dump("R10");

    por();
    for (int i = 0; i < 8; i++) begin goto_adr(64 + i); cmd(1'b1, "R8"); end
    goto_adr(64); cmd(1'b1, "R8");
    goto_adr(71); cmd(1'b1, "R8");
    goto_adr(70); run_code(-1);
    goto_adr(20); cmd(1'b1, "R8");
    dump("R8");
    for (int k = 0; k < 30; k++) rop("R11", 1'b0);
    dump("R11");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule